// File: doc/BRIEF.md
# CAN Interrupt Flag and Error Capture Unit

This unit collects the event pulses a CAN-style protocol engine produces and turns them into interrupt flags, one combined interrupt line and two frozen capture bytes. The engine reports a received frame, a finished transmission, a change of error-warning status, entry into error passive, a lost arbitration with the bit position where it was lost, and a bus error with its type, direction and frame segment. Software sees four byte-wide registers through a small register port. These are the flag byte, the enable byte, the arbitration capture and the bus-error capture. Reading some of them has side effects.

The flag byte is cleared by reading it, except for the receive flag. The receive flag follows the presence of a pending received frame. Each capture register latches the first event after it is armed and then holds that value. Further events of that kind are ignored until software reads the capture, which arms it again. The enable byte can only be changed while the controller is held in reset mode. One of its bits is a baud-prescaler doubling control and has no effect on interrupts.

Top module: `can_irq_capture`

## Requirements
- R1: Flag bit positions are receive 0, transmit 1, error warning 2, error passive 5, arbitration lost 6 and bus error 7. An event sets its flag only if the matching enable bit is 1 in the cycle of the event. Flag bits 3 and 4 always read 0.
- R2: A read strobe at address 0 (the flag byte) clears flag bits 1, 2, 5, 6 and 7 on the next clock edge. A flag whose event arrives in the same cycle as that read is set after the edge.
- R3: The receive flag is not cleared by reading the flag byte. It stays set while `rx_pending` is 1 and clears on the first edge where `rx_pending` is 0 and no receive event arrives.
- R4: `irq` is 1 exactly when some flag bit and its enable bit are both 1. Clearing an enable bit drops `irq` without clearing the flag.
- R5: Address 2 reads {3'b000, bit position} of the last captured arbitration loss. The capture is taken whether or not the flag is enabled. It then freezes: later losses neither update it nor set the flag. A read strobe at address 2 re-arms it, and a loss that falls in the same cycle as that re-arming read is dropped.
- R6: Address 3 reads {type[1:0], direction, segment[4:0]} of the captured bus error. Type 0 is a bit error, 1 a form error, 2 a stuff error and 3 any other error. Direction 0 is transmit and 1 is receive. Freezing and re-arming by a read at address 3 behave as in R5.
- R7: The enable byte at address 1 is written only when `reg_wr` is 1 and `reset_mode` is 1. Other writes leave it unchanged. Bit 3 is reserved and reads 0.
- R8: Bit 4 of the enable byte is stored by the same write and drives `presc_double`. It sets no flag and never raises `irq`.
- R9: After reset, all four registers read 0, `irq` and `presc_double` are 0, and both captures are armed.
- R10: `reg_rdata` shows the register selected by `reg_addr` at all times. Read side effects happen only on an edge where `reg_rd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reset_mode | input | 1 | Controller held in reset mode; opens the enable byte for writes |
| rx_pending | input | 1 | A received frame is still waiting in the receive buffer |
| ev_rx | input | 1 | Pulse: frame received |
| ev_tx | input | 1 | Pulse: transmission finished |
| ev_err_warn | input | 1 | Pulse: error-warning status changed |
| ev_err_passive | input | 1 | Pulse: error-passive status changed |
| ev_arb_lost | input | 1 | Pulse: arbitration lost |
| arb_bit_pos | input | 5 | Bit position of the arbitration loss |
| ev_bus_err | input | 1 | Pulse: bus error detected |
| berr_type | input | 2 | Bus error type code |
| berr_dir | input | 1 | Bus error direction, 0 transmit, 1 receive |
| berr_seg | input | 5 | Frame segment code of the bus error |
| reg_addr | input | 2 | Register select: 0 flags, 1 enable, 2 arbitration capture, 3 bus-error capture |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (triggers side effects) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| presc_double | output | 1 | Baud-prescaler doubling control from enable bit 4 |
| irq | output | 1 | Combined interrupt request |

## Verification
The main collision is a read of the flag byte in the same cycle as a new event. The read clears the old flags, and the new event must still be set after the edge. A second collision is a re-arming capture read that meets a new event of the same kind. The bench provokes both by driving the read strobe and the event pulse in one cycle. For the flag byte, it checks the value returned by the read (the old flags) and then the flags left afterwards. For the captures, it checks that the colliding event was dropped and that the next event is captured.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
  localparam int REG_W     = 8;
  localparam int ADDR_W    = 2;
  localparam int ARB_POS_W = 5;
  localparam int SEG_W     = 5;
  localparam int BTYPE_W   = 2;

  typedef enum logic [ADDR_W-1:0] {
    RA_FLAGS  = 2'd0,
    RA_ENABLE = 2'd1,
    RA_ARB    = 2'd2,
    RA_BERR   = 2'd3
  } reg_addr_e;

  localparam int B_RX    = 0;
  localparam int B_TX    = 1;
  localparam int B_WARN  = 2;
  localparam int B_PRESC = 4;
  localparam int B_PASS  = 5;
  localparam int B_ARB   = 6;
  localparam int B_BERR  = 7;

  localparam logic [REG_W-1:0] FLAG_MASK =
    (REG_W'(1) << B_RX) | (REG_W'(1) << B_TX) | (REG_W'(1) << B_WARN) |
    (REG_W'(1) << B_PASS) | (REG_W'(1) << B_ARB) | (REG_W'(1) << B_BERR);
  localparam logic [REG_W-1:0] CLR_ON_READ = FLAG_MASK & ~(REG_W'(1) << B_RX);
  localparam logic [REG_W-1:0] ENREG_MASK  = FLAG_MASK | (REG_W'(1) << B_PRESC);

  function automatic logic [REG_W-1:0] pack_arb(input logic [ARB_POS_W-1:0] pos);
    return REG_W'(pos);
  endfunction

  function automatic logic [REG_W-1:0] pack_berr(input logic [BTYPE_W-1:0] kind,
                                                 input logic dir,
                                                 input logic [SEG_W-1:0] seg);
    return {kind, dir, seg};
  endfunction

  // Next flag byte: read clears all but receive; receive follows pending level.
  function automatic logic [REG_W-1:0] next_flags(input logic [REG_W-1:0] cur,
                                                  input logic [REG_W-1:0] set,
                                                  input logic rd_clear,
                                                  input logic rx_hold);
    logic [REG_W-1:0] kept;
    kept = cur & ~(rd_clear ? CLR_ON_READ : '0);
    kept[B_RX] = cur[B_RX] & rx_hold;
    return (kept | set) & FLAG_MASK;
  endfunction
endpackage

// File: rtl/can_irq_capture_slot.sv
module can_irq_capture_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ev,
  input  logic [W-1:0] din,
  input  logic         rearm,
  output logic [W-1:0] value,
  output logic         armed,
  output logic         fire
);
  logic [W-1:0] val_q;
  logic         armed_q;

  assign fire  = ev & armed_q;
  assign value = val_q;
  assign armed = armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q   <= '0;
      armed_q <= 1'b1;
    end else if (fire) begin
      val_q   <= din;
      armed_q <= 1'b0;
    end else if (rearm) begin
      armed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/can_irq_enable_reg.sv
module can_irq_enable_reg
  import can_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             cfg_open,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] en_q,
  output logic [REG_W-1:0] en_mask,
  output logic             presc_double
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              en_q <= '0;
    else if (wr && cfg_open) en_q <= wdata & ENREG_MASK;
  end

  assign en_mask      = en_q & FLAG_MASK;
  assign presc_double = en_q[B_PRESC];
endmodule

// File: rtl/can_irq_flag_bank.sv
module can_irq_flag_bank
  import can_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] set_req,
  input  logic [REG_W-1:0] en_mask,
  input  logic             rd_clear,
  input  logic             rx_pending,
  output logic [REG_W-1:0] flags,
  output logic [REG_W-1:0] set_vec,
  output logic             irq
);
  assign set_vec = set_req & en_mask & FLAG_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= next_flags(flags, set_vec, rd_clear, rx_pending);
  end

  assign irq = |(flags & en_mask);
endmodule

// File: rtl/can_irq_capture.sv
module can_irq_capture
  import can_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reset_mode,
  input  logic                 rx_pending,
  input  logic                 ev_rx,
  input  logic                 ev_tx,
  input  logic                 ev_err_warn,
  input  logic                 ev_err_passive,
  input  logic                 ev_arb_lost,
  input  logic [ARB_POS_W-1:0] arb_bit_pos,
  input  logic                 ev_bus_err,
  input  logic [BTYPE_W-1:0]   berr_type,
  input  logic                 berr_dir,
  input  logic [SEG_W-1:0]     berr_seg,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  output logic                 presc_double,
  output logic                 irq
);
  reg_addr_e        sel;
  logic             rd_flags, rd_arb, rd_berr, wr_enable;
  logic [REG_W-1:0] en_q, en_mask, flags, set_req, set_vec;
  logic [REG_W-1:0] arb_cap, berr_cap;
  logic             arb_armed, arb_fire, berr_armed, berr_fire;

  assign sel       = reg_addr_e'(reg_addr);
  assign rd_flags  = reg_rd && (sel == RA_FLAGS);
  assign rd_arb    = reg_rd && (sel == RA_ARB);
  assign rd_berr   = reg_rd && (sel == RA_BERR);
  assign wr_enable = reg_wr && (sel == RA_ENABLE);

  can_irq_enable_reg u_enable (
    .clk(clk), .rst_n(rst_n), .wr(wr_enable), .cfg_open(reset_mode),
    .wdata(reg_wdata), .en_q(en_q), .en_mask(en_mask), .presc_double(presc_double)
  );

  can_irq_capture_slot #(.W(REG_W)) u_arb_slot (
    .clk(clk), .rst_n(rst_n), .ev(ev_arb_lost), .din(pack_arb(arb_bit_pos)),
    .rearm(rd_arb), .value(arb_cap), .armed(arb_armed), .fire(arb_fire)
  );

  can_irq_capture_slot #(.W(REG_W)) u_berr_slot (
    .clk(clk), .rst_n(rst_n), .ev(ev_bus_err),
    .din(pack_berr(berr_type, berr_dir, berr_seg)),
    .rearm(rd_berr), .value(berr_cap), .armed(berr_armed), .fire(berr_fire)
  );

  always_comb begin
    set_req         = '0;
    set_req[B_RX]   = ev_rx;
    set_req[B_TX]   = ev_tx;
    set_req[B_WARN] = ev_err_warn;
    set_req[B_PASS] = ev_err_passive;
    set_req[B_ARB]  = arb_fire;
    set_req[B_BERR] = berr_fire;
  end

  can_irq_flag_bank u_flags (
    .clk(clk), .rst_n(rst_n), .set_req(set_req), .en_mask(en_mask),
    .rd_clear(rd_flags), .rx_pending(rx_pending), .flags(flags),
    .set_vec(set_vec), .irq(irq)
  );

  always_comb begin
    unique case (sel)
      RA_FLAGS:  reg_rdata = flags;
      RA_ENABLE: reg_rdata = en_q;
      RA_ARB:    reg_rdata = arb_cap;
      RA_BERR:   reg_rdata = berr_cap;
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/can_irq_capture_checker.sv
module can_irq_capture_checker
  import can_irq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             reset_mode,
  input logic             rx_pending,
  input logic             reg_rd,
  input logic             reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [REG_W-1:0] flags,
  input logic [REG_W-1:0] en_q,
  input logic [REG_W-1:0] en_mask,
  input logic [REG_W-1:0] set_vec,
  input logic [REG_W-1:0] arb_cap,
  input logic [REG_W-1:0] berr_cap,
  input logic             arb_armed,
  input logic             berr_armed,
  input logic             irq
);
  AST_FLAG_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & ~$past(flags) & ~$past(en_mask)) == '0)); // R1
  AST_RSVD_FLAGS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (flags & ~FLAG_MASK) == '0); // R1
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == RA_FLAGS) |=> ((flags & CLR_ON_READ & ~$past(set_vec)) == '0)); // R2
  AST_RX_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_pending && !set_vec[B_RX]) |=> !flags[B_RX]); // R3
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == '0) |-> !irq); // R4
  AST_ARB_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !arb_armed |=> $stable(arb_cap)); // R5
  AST_BERR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !berr_armed |=> $stable(berr_cap)); // R6
  AST_ENABLE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !(reset_mode && reg_wr && reg_addr == RA_ENABLE) |=> $stable(en_q)); // R7
endmodule

bind can_irq_capture can_irq_capture_checker i_checker (
  .clk(clk), .rst_n(rst_n), .reset_mode(reset_mode), .rx_pending(rx_pending),
  .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr), .flags(flags),
  .en_q(en_q), .en_mask(en_mask), .set_vec(set_vec), .arb_cap(arb_cap),
  .berr_cap(berr_cap), .arb_armed(arb_armed), .berr_armed(berr_armed), .irq(irq)
);

// File: tb/test_can_irq_capture.sv
`timescale 1ns/1ps
module test_can_irq_capture;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reset_mode = 1'b1, rx_pending = 1'b0;
  logic       ev_rx = 0, ev_tx = 0, ev_err_warn = 0, ev_err_passive = 0;
  logic       ev_arb_lost = 0, ev_bus_err = 0, berr_dir = 0;
  logic [4:0] arb_bit_pos = 0, berr_seg = 0;
  logic [1:0] berr_type = 0, reg_addr = 0;
  logic       reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic       presc_double, irq;

  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  can_irq_capture i_can_irq_capture (.*);

  // enable, events, expected flags, expected irq
  typedef struct packed { logic [7:0] en; logic [7:0] ev; logic [7:0] exp; logic irq; } vec_t;
  localparam vec_t VECS [6] = '{
    '{8'hFF, 8'h01, 8'h01, 1'b1},
    '{8'hFF, 8'hE6, 8'hE6, 1'b1},
    '{8'h02, 8'hE7, 8'h02, 1'b1},
    '{8'h00, 8'hE7, 8'h00, 1'b0},
    '{8'h10, 8'h27, 8'h00, 1'b0},
    '{8'hA4, 8'hA5, 8'hA4, 1'b1}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // One cycle, called at a negedge: drive, sample rdata before the edge, release.
  task automatic step(input logic rd, input logic wr, input logic [1:0] a,
                      input logic [7:0] wd, input logic [7:0] ev, output logic [7:0] rv);
    reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = wd;
    ev_rx = ev[0]; ev_tx = ev[1]; ev_err_warn = ev[2];
    ev_err_passive = ev[5]; ev_arb_lost = ev[6]; ev_bus_err = ev[7];
    #1 rv = reg_rdata;
    @(negedge clk);
    reg_rd = 0; reg_wr = 0;
    {ev_rx, ev_tx, ev_err_warn, ev_err_passive, ev_arb_lost, ev_bus_err} = '0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] rv);
    reg_addr = a; #1 rv = reg_rdata;
  endtask

  task automatic clear_all();
    logic [7:0] d;
    rx_pending = 0;
    step(1, 0, 2'd0, 0, 0, d);
    step(1, 0, 2'd2, 0, 0, d);
    step(1, 0, 2'd3, 0, 0, d);
    rx_pending = 1;
  endtask

  task automatic set_en(input logic [7:0] v);
    logic [7:0] d;
    reset_mode = 1;
    step(0, 1, 2'd1, v, 0, d);
  endtask

  initial begin
    #800000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    // R9 reset state
    for (int a = 0; a < 4; a++) begin peek(a[1:0], v); chk("R9 reset register", v, 8'h00); end
    chk("R9 reset irq", {7'b0, irq}, 8'h00);
    rst_n = 1;
    @(negedge clk);
    chk("R9 presc_double after reset", {7'b0, presc_double}, 8'h00);

    // table walk: R1 enable gating, R4 irq, R8 bit4 not an enable
    foreach (VECS[i]) begin
      clear_all();
      set_en(VECS[i].en);
      arb_bit_pos = 5'd1; berr_type = 2'd0; berr_seg = 5'd1;
      step(0, 0, 2'd0, 0, VECS[i].ev, v);
      peek(2'd0, v);
      chk("R1 flags from event vector", v, VECS[i].exp);
      chk("R4 irq from event vector", {7'b0, irq}, {7'b0, VECS[i].irq});
    end

    // R7 write gating and reserved bit 3
    clear_all();
    set_en(8'hFF);
    peek(2'd1, v); chk("R7 enable readback bit3 zero", v, 8'hF7);
    chk("R8 presc_double from bit4", {7'b0, presc_double}, 8'h01);
    reset_mode = 0;
    step(0, 1, 2'd1, 8'h00, 0, v);
    peek(2'd1, v); chk("R7 write ignored outside reset mode", v, 8'hF7);
    set_en(8'h10);
    peek(2'd1, v); chk("R8 bit4 alone stored", v, 8'h10);
    step(0, 0, 2'd0, 0, 8'h02, v);
    chk("R8 bit4 never raises irq", {7'b0, irq}, 8'h00);

    // R2 and R3: read clears all but receive
    clear_all();
    set_en(8'hFF);
    arb_bit_pos = 5'd2;
    step(0, 0, 2'd0, 0, 8'h43, v);
    step(1, 0, 2'd0, 0, 0, v);
    chk("R2 read returns flags", v, 8'h43);
    peek(2'd0, v); chk("R3 receive survives read", v, 8'h01);
    rx_pending = 0;
    step(0, 0, 2'd0, 0, 0, v);
    peek(2'd0, v); chk("R3 receive clears when not pending", v, 8'h00);
    chk("R4 irq low with no flags", {7'b0, irq}, 8'h00);

    // R2 same-cycle read and event
    clear_all(); rx_pending = 0;
    step(0, 0, 2'd0, 0, 8'h04, v);
    step(1, 0, 2'd0, 0, 8'h02, v);
    chk("R2 colliding read returns old flags", v, 8'h04);
    peek(2'd0, v); chk("R2 colliding event survives read", v, 8'h02);

    // R4 dropping an enable bit lowers irq but keeps flag
    chk("R4 irq with tx flag", {7'b0, irq}, 8'h01);
    set_en(8'hFD);
    chk("R4 irq dropped by enable", {7'b0, irq}, 8'h00);
    peek(2'd0, v); chk("R4 flag kept after enable drop", v, 8'h02);
    set_en(8'hFF);
    chk("R4 irq back with enable", {7'b0, irq}, 8'h01);

    // R5 arbitration capture
    clear_all(); rx_pending = 0;
    arb_bit_pos = 5'd13; step(0, 0, 2'd0, 0, 8'h40, v);
    peek(2'd2, v); chk("R5 capture position", v, 8'h0D);
    arb_bit_pos = 5'd7; step(0, 0, 2'd0, 0, 8'h40, v);
    peek(2'd2, v); chk("R5 frozen capture", v, 8'h0D);
    step(1, 0, 2'd0, 0, 0, v);
    step(0, 0, 2'd0, 0, 8'h40, v);
    peek(2'd0, v); chk("R5 frozen loss sets no flag", v, 8'h00);
    step(1, 0, 2'd2, 0, 0, v); chk("R5 capture read value", v, 8'h0D);
    arb_bit_pos = 5'd9; step(0, 0, 2'd0, 0, 8'h40, v);
    peek(2'd2, v); chk("R5 rearmed capture", v, 8'h09);
    peek(2'd0, v); chk("R5 rearmed flag", v, 8'h40);
    arb_bit_pos = 5'd3; step(1, 0, 2'd2, 0, 8'h40, v);
    peek(2'd2, v); chk("R5 loss during rearm read dropped", v, 8'h09);
    arb_bit_pos = 5'd4; step(0, 0, 2'd0, 0, 8'h40, v);
    peek(2'd2, v); chk("R5 capture after collision", v, 8'h04);

    // R6 bus-error capture: type stuff(2), receive(1), segment 0x1A -> BA
    clear_all(); rx_pending = 0;
    berr_type = 2'd2; berr_dir = 1; berr_seg = 5'h1A;
    step(0, 0, 2'd0, 0, 8'h80, v);
    peek(2'd3, v); chk("R6 capture layout", v, 8'hBA);
    peek(2'd0, v); chk("R6 bus error flag", v, 8'h80);
    berr_type = 2'd0; berr_dir = 0; berr_seg = 5'h03;
    step(0, 0, 2'd0, 0, 8'h80, v);
    peek(2'd3, v); chk("R6 frozen capture", v, 8'hBA);
    step(1, 0, 2'd3, 0, 0, v); chk("R6 capture read value", v, 8'hBA);
    berr_type = 2'd1; berr_dir = 0; berr_seg = 5'h05;
    step(0, 0, 2'd0, 0, 8'h80, v);
    peek(2'd3, v); chk("R6 rearmed form error transmit", v, 8'h45);

    // R10 read side effects need the strobe
    clear_all(); rx_pending = 0;
    step(0, 0, 2'd0, 0, 8'h02, v);
    peek(2'd0, v); peek(2'd0, v);
    @(negedge clk);
    peek(2'd0, v); chk("R10 no strobe no clear", v, 8'h02);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule